// File: doc/BRIEF.md
# Phase-Aligned Half-Rate Clock Generator

This block runs on a fast clock at twice the wanted output rate and produces a registered square wave at half the fast rate. A free-running toggle flip-flop would start in either of its two phases after reset, so the block also takes a reference at one quarter of the fast rate. The reference is treated as an ordinary data input. It is sampled with the fast clock, a change in the sampled stream is detected, and the toggle register is forced into the phase whose rising edges line up with the reference's rising edges. The phase is found by watching the reference, never by trusting the power-up value of any register.

Two correction schemes are available through a parameter. In the edge-clear scheme the output register is cleared during the first fast cycle in which the sampled reference reads high. In the transition scheme the next output value is the inverse of the current output ORed with a change detector, so both reference edges correct the phase. A second parameter picks whether the reference is captured on the rising or the falling fast-clock edge. A sticky lock flag rises on the first correction event after reset. The reset is asynchronous and active low, and the block releases it internally in step with the fast clock.

Top module: `half_rate_aligner`

## Requirements
- R1: While rst_n is low, clk_half holds the value of parameter OUT_RESET and locked is 0, whatever ref_in does.
- R2: With default parameters (SYNC_STAGES = 2) and a running reference, locked is high no later than the 12th falling fast-clock edge after rst_n is released at a falling edge.
- R3: Once locked is high, clk_half changes value on every rising fast-clock edge, which gives a period of two fast cycles and a 50% duty cycle.
- R4: Let ref_in change just after a rising fast-clock edge E. When sampling on the falling edge (SAMPLE_FALLING = 1), clk_half rises at the same edge E at which ref_in went high. When sampling on the rising edge (SAMPLE_FALLING = 0), clk_half rises at the next rising edge after E. This holds from the first cycle in which locked reads high.
- R5: Once locked is high it stays high until rst_n goes low.
- R6: Lock and phase are correct for both values of OUT_RESET and for every phase of the reference relative to the release of reset.
- R7: No sample pair is used for correction until both samples were captured after reset. A reference that is already high when reset releases therefore never causes a false correction.
- R8: SCHEME = SCHEME_EDGE_CLEAR (encoding 0) corrects and locks only on a sampled low-to-high change. SCHEME = SCHEME_XOR (encoding 1) corrects and locks on a change in either direction. Under the same conditions, the transition scheme locks no later than the edge-clear scheme, and both give the same steady waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock at twice the output rate |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| ref_in | input | 1 | Quarter-rate phase reference, treated as data |
| clk_half | output | 1 | Registered half-rate output |
| locked | output | 1 | Sticky flag: phase has been corrected at least once since reset |

## Verification
If the toggle register sits in the inverted phase after lock, clk_half is low on the edge where the reference rises. The port comparison shows this within one fast cycle of locked rising. If the sample pair is qualified wrongly or the change detector is broken, the block either raises locked at a moment when the output is still in the wrong phase, or never raises it. The first shows as a phase mismatch in the lock cycle itself. The second shows once the twelve-cycle lock window expires. A scheme mix-up shows up as the transition scheme locking later than the edge-clear scheme for the same reference offset.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  // Selects how the phase correction event is formed.
  typedef enum logic {
    SCHEME_EDGE_CLEAR = 1'b0,  // clear on sampled low-to-high reference change
    SCHEME_XOR        = 1'b1   // clear on any sampled reference change
  } div_scheme_e;

endpackage

// File: rtl/hdiv_rst_sync.sv
module hdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] shift_q;
  logic [MSB:0] shift_d;

  // Next state: shift a constant one toward the output end.
  always_comb begin
    shift_d = (shift_q << 1) | STAGES'(1);
  end

  // Asserts at once, releases after STAGES rising edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign srst_n = shift_q[MSB];

endmodule

// File: rtl/hdiv_ref_sampler.sv
module hdiv_ref_sampler #(
  parameter bit SAMPLE_FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_now,
  output logic ref_prev,
  output logic pair_valid
);

  logic cap_q;     // first capture of the reference
  logic cap_vld_q; // cap_q holds a genuine post-reset sample
  logic dly_q;     // previous capture, on the rising edge
  logic dly_vld_q; // dly_q holds a genuine post-reset sample
  logic dly_d;
  logic dly_vld_d;

  generate
    if (SAMPLE_FALLING) begin : g_fall
      // Capture half a cycle ahead of the correcting edge.
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q     <= 1'b0;
          cap_vld_q <= 1'b0;
        end else begin
          cap_q     <= ref_in;
          cap_vld_q <= 1'b1;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q     <= 1'b0;
          cap_vld_q <= 1'b0;
        end else begin
          cap_q     <= ref_in;
          cap_vld_q <= 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    dly_d     = cap_q;
    dly_vld_d = cap_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q     <= 1'b0;
      dly_vld_q <= 1'b0;
    end else begin
      dly_q     <= dly_d;
      dly_vld_q <= dly_vld_d;
    end
  end

  assign ref_now    = cap_q;
  assign ref_prev   = dly_q;
  assign pair_valid = cap_vld_q & dly_vld_q;

  // R7
  pair_valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> pair_valid);

endmodule

// File: rtl/hdiv_phase_core.sv
module hdiv_phase_core
  import hdiv_pkg::*;
#(
  parameter div_scheme_e SCHEME    = SCHEME_XOR,
  parameter bit          OUT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_now,
  input  logic ref_prev,
  input  logic pair_valid,
  output logic clk_half,
  output logic locked
);

  logic evt;
  logic half_q, half_d;
  logic lock_q, lock_d, lock_en;

  generate
    if (SCHEME == SCHEME_EDGE_CLEAR) begin : g_edge
      always_comb begin
        evt    = pair_valid & ref_now & ~ref_prev;
        half_d = evt ? 1'b0 : ~half_q;
      end
    end else begin : g_xor
      always_comb begin
        evt    = pair_valid & (ref_now ^ ref_prev);
        half_d = ~(half_q | evt);
      end
    end
  endgenerate

  always_comb begin
    lock_en = evt & ~lock_q;
    lock_d  = lock_q | lock_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= OUT_RESET;
      lock_q <= 1'b0;
    end else begin
      half_q <= half_d;
      if (lock_en) begin
        lock_q <= lock_d;
      end
    end
  end

  assign clk_half = half_q;
  assign locked   = lock_q;

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R3
  toggle_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> (clk_half != $past(clk_half)));

  // R4
  rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && pair_valid && ref_now && !ref_prev) |-> clk_half);

  // R7
  lock_needs_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> !locked);

endmodule

// File: rtl/half_rate_aligner.sv
module half_rate_aligner
  import hdiv_pkg::*;
#(
  parameter div_scheme_e SCHEME         = SCHEME_XOR,
  parameter bit          SAMPLE_FALLING = 1'b1,
  parameter bit          OUT_RESET      = 1'b0,
  parameter int          SYNC_STAGES    = 2
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic ref_in,
  output logic clk_half,
  output logic locked
);

  logic srst_n;
  logic ref_now, ref_prev, pair_valid;

  hdiv_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk_fast),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  hdiv_ref_sampler #(
    .SAMPLE_FALLING (SAMPLE_FALLING)
  ) u_sampler (
    .clk        (clk_fast),
    .rst_n      (srst_n),
    .ref_in     (ref_in),
    .ref_now    (ref_now),
    .ref_prev   (ref_prev),
    .pair_valid (pair_valid)
  );

  hdiv_phase_core #(
    .SCHEME    (SCHEME),
    .OUT_RESET (OUT_RESET)
  ) u_core (
    .clk        (clk_fast),
    .rst_n      (srst_n),
    .ref_now    (ref_now),
    .ref_prev   (ref_prev),
    .pair_valid (pair_valid),
    .clk_half   (clk_half),
    .locked     (locked)
  );

endmodule

// File: tb/half_rate_aligner_tb.sv
module half_rate_aligner_tb;
  import hdiv_pkg::*;

  localparam int NINST      = 8;
  localparam int LOCK_LIMIT = 12;
  localparam int RUN_CYCLES = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic [1:0] ph = 2'd0;
  logic [NINST-1:0] half_w;
  logic [NINST-1:0] lock_w;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int lock_at [NINST];

  always #4 clk = ~clk;  // 125 MHz

  // Reference: high for two fast cycles, low for two, changing 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    ph     = ph + 2'd1;
    ref_in = (ph < 2'd2);
  end

  // Instance index bit 2: scheme, bit 1: falling-edge sampling, bit 0: output reset value.
  for (genvar gi = 0; gi < NINST; gi++) begin : g_dut
    localparam div_scheme_e SC = (((gi >> 2) & 1) == 1) ? SCHEME_XOR : SCHEME_EDGE_CLEAR;
    localparam bit FALL = (((gi >> 1) & 1) == 1);
    localparam bit RSTV = ((gi & 1) == 1);
    half_rate_aligner #(
      .SCHEME         (SC),
      .SAMPLE_FALLING (FALL),
      .OUT_RESET      (RSTV),
      .SYNC_STAGES    (2)
    ) u_dut (
      .clk_fast (clk),
      .rst_n    (rst_n),
      .ref_in   (ref_in),
      .clk_half (half_w[gi]),
      .locked   (lock_w[gi])
    );
  end

  task automatic check(input bit ok, input string req, input int inst, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s inst %0d: actual %0d expected %0d", req, inst, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int off = 0; off < 4; off++) begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      for (int i = 0; i < NINST; i++) begin
        check(half_w[i] == i[0], "R1 clk_half in reset", i, int'(half_w[i]), i & 1);
        check(lock_w[i] == 1'b0, "R1 locked in reset", i, int'(lock_w[i]), 0);
        lock_at[i] = -1;
      end
      // R6: release at each of the four reference phases
      repeat (off) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int cyc = 1; cyc <= RUN_CYCLES; cyc++) begin
        @(negedge clk);
        for (int i = 0; i < NINST; i++) begin
          if (lock_w[i]) begin
            int expv;
            if (lock_at[i] < 0) lock_at[i] = cyc;
            // R4, R3, R7: phase matches from the first locked cycle
            expv = ((i >> 1) & 1) == 1 ? int'(!ph[0]) : int'(ph[0]);
            check(int'(half_w[i]) == expv, "R4 phase after lock", i, int'(half_w[i]), expv);
          end else if (lock_at[i] >= 0) begin
            // R5: lock never drops
            check(1'b0, "R5 locked dropped", i, 0, 1);
          end
        end
      end
      for (int i = 0; i < NINST; i++) begin
        // R2: lock window
        check(lock_at[i] > 0 && lock_at[i] <= LOCK_LIMIT, "R2 lock time", i, lock_at[i], LOCK_LIMIT);
      end
      for (int j = 0; j < 4; j++) begin
        // R8: transition scheme locks no later than edge-clear scheme
        check(lock_at[j + 4] <= lock_at[j], "R8 scheme lock order", j + 4, lock_at[j + 4], lock_at[j]);
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule